// File: doc/BRIEF.md
# Serial NOR Flash Write-Protection Controller

This block holds the protection state of a serial NOR flash and rules on every modifying request the command decoder hands it. A status register holds a 3-bit protect-size field, a sticky register-lock bit and the write-enable latch. A configuration register holds a top/bottom select bit and a quad-enable bit. Each cycle with `cmd_valid` high carries one decoded operation: write enable, register write, page program or sector erase. The operation comes with a 24-bit target address and, for a register write, the new register images.

One cycle later the block answers with either `cmd_accept` or `cmd_reject`, and the registers change on the same edge. Program and erase requests are refused when they land inside the protected range. A register write is refused while the external guard pin is held low and the lock bit is set. Quad mode turns that pin into a data line, so the pin lock stops applying when quad mode is on. Every refusal also raises `err_pulse` for that cycle.

Top module: `flash_wprot_ctrl`

## Requirements
- R1: After reset, `status_q`, `config_q`, `cmd_accept`, `cmd_reject` and `err_pulse` are all 0.
- R2: Operation code 2'b00 (write enable) is always accepted, and it sets the write-enable latch, which is status bit 1.
- R3: The modifying operations are 2'b01 (register write), 2'b10 (page program) and 2'b11 (sector erase). Each is rejected when the latch is 0. The latch reads 0 after any modifying operation, whether it was accepted or rejected.
- R4: An accepted register write copies `new_status[7]` (lock) and `new_status[4:2]` (protect size) into the status register. It copies `new_config[5]` (bottom select) and `new_config[1]` (quad enable) into the configuration register. Every other register bit, apart from the latch, reads 0.
- R5: While `guard_pin_n` is 0, status bit 7 is 1 and config bit 1 is 0, a register write is rejected. Both registers, including the lock bit, keep their values.
- R6: The lock takes effect whether the lock bit was set before or after the pin went low. With the pin high, register writes are accepted.
- R7: With config bit 1 set, register writes are accepted even when the pin is low and the lock bit is 1.
- R8: A protect size of 0 protects nothing. A size n from 1 to 6 protects 2^(n-1)/64 of the array. A size of 7 protects the whole array.
- R9: When config bit 5 is 0, the protected range ends at the highest array address. When it is 1, the range starts at address 0.
- R10: A program or erase request whose address lies inside the protected range is rejected, whether or not the registers are locked. The same request outside the range is accepted when the latch is set.
- R11: `cmd_accept` or `cmd_reject` goes high for exactly the cycle after a `cmd_valid` cycle. `err_pulse` follows `cmd_reject`. Neither output rises without a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| guard_pin_n | input | 1 | External write-guard pin level (low = guard) |
| cmd_valid | input | 1 | One-cycle strobe for a decoded operation |
| cmd_op | input | 2 | Operation code |
| cmd_addr | input | 24 | Target byte address for program or erase |
| new_status | input | 8 | Status image for a register write |
| new_config | input | 8 | Configuration image for a register write |
| cmd_accept | output | 1 | Operation granted (one cycle) |
| cmd_reject | output | 1 | Operation refused (one cycle) |
| err_pulse | output | 1 | Refusal marker, one cycle |
| status_q | output | 8 | Status register contents |
| config_q | output | 8 | Configuration register contents |

## Verification
The properties assume that `cmd_op`, `cmd_addr`, the register images and `guard_pin_n` are steady across the edge that samples a command. They also assume that `cmd_op` is meaningful only while `cmd_valid` is high. The bench changes all inputs at falling edges and issues one command followed by a low-strobe cycle. The pin moves only between commands, so each ruling depends on a single pin level.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
  typedef enum logic [1:0] {
    OP_WREN  = 2'b00,
    OP_REGWR = 2'b01,
    OP_PROG  = 2'b10,
    OP_ERASE = 2'b11
  } fwp_op_e;

  // Protected-range membership: size field, bottom select, offset, array log2
  function automatic logic range_hit_f(input logic [2:0] bp, input logic bottom,
                                       input logic [31:0] off, input int arr_log2);
    logic [32:0] total;
    logic [32:0] span;
    total = 33'd1 << arr_log2;
    if (bp == 3'd0) return 1'b0;
    if (bp == 3'd7) return 1'b1;
    span = 33'd1 << (arr_log2 - 7 + int'(bp));
    if (bottom) return ({1'b0, off} < span);
    return ({1'b0, off} >= (total - span));
  endfunction
endpackage

// File: rtl/fwp_range_chk.sv
module fwp_range_chk #(
  parameter int ADDR_W     = 24,
  parameter int ARRAY_LOG2 = 24
) (
  input  logic [2:0]        bp,
  input  logic              bottom,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam logic [31:0] OFF_MASK = (ARRAY_LOG2 >= 32) ? 32'hFFFF_FFFF
                                   : ((32'd1 << ARRAY_LOG2) - 32'd1);
  logic [31:0] offset;

  assign offset = 32'(addr) & OFF_MASK;
  assign hit    = fwp_pkg::range_hit_f(bp, bottom, offset, ARRAY_LOG2);
endmodule

// File: rtl/fwp_gate.sv
module fwp_gate (
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       wel,
  input  logic       lock_bit,
  input  logic       quad_en,
  input  logic       guard_pin_n,
  input  logic       range_hit,
  output logic       lock_active,
  output logic       grant,
  output logic       deny
);
  import fwp_pkg::*;
  logic allowed;

  // quad mode repurposes the pin as a data line, so the pin lock drops out
  assign lock_active = lock_bit & ~guard_pin_n & ~quad_en;

  always_comb begin
    case (fwp_op_e'(cmd_op))
      OP_WREN:  allowed = 1'b1;
      OP_REGWR: allowed = wel & ~lock_active;
      default:  allowed = wel & ~range_hit;
    endcase
  end

  assign grant = cmd_valid & allowed;
  assign deny  = cmd_valid & ~allowed;
endmodule

// File: rtl/fwp_regs.sv
module fwp_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cmd_op,
  input  logic       grant,
  input  logic       deny,
  input  logic       wr_lock,
  input  logic [2:0] wr_bp,
  input  logic       wr_bottom,
  input  logic       wr_quad,
  output logic       lock_q,
  output logic [2:0] bp_q,
  output logic       bottom_q,
  output logic       quad_q,
  output logic       wel_q,
  output logic       acc_q,
  output logic       rej_q
);
  import fwp_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q   <= 1'b0;
      bp_q     <= 3'd0;
      bottom_q <= 1'b0;
      quad_q   <= 1'b0;
      wel_q    <= 1'b0;
      acc_q    <= 1'b0;
      rej_q    <= 1'b0;
    end else begin
      acc_q <= grant;
      rej_q <= deny;
      if (grant) begin
        case (fwp_op_e'(cmd_op))
          OP_WREN: wel_q <= 1'b1;
          OP_REGWR: begin
            lock_q   <= wr_lock;
            bp_q     <= wr_bp;
            bottom_q <= wr_bottom;
            quad_q   <= wr_quad;
            wel_q    <= 1'b0;
          end
          default: wel_q <= 1'b0;
        endcase
      end else if (deny) begin
        wel_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/flash_wprot_ctrl.sv
module flash_wprot_ctrl #(
  parameter int ADDR_W     = 24,
  parameter int ARRAY_LOG2 = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              guard_pin_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        new_status,
  input  logic [7:0]        new_config,
  output logic              cmd_accept,
  output logic              cmd_reject,
  output logic              err_pulse,
  output logic [7:0]        status_q,
  output logic [7:0]        config_q
);
  logic       lock_q, bottom_q, quad_q, wel_q;
  logic [2:0] bp_q;
  logic       range_hit, lock_active, grant, deny;
  logic       acc_q, rej_q;
  logic       unused_bits;

  assign unused_bits = ^{new_status[6:5], new_status[1:0],
                         new_config[7:6], new_config[4:2], new_config[0]};

  fwp_range_chk #(.ADDR_W(ADDR_W), .ARRAY_LOG2(ARRAY_LOG2)) u_range (
    .bp(bp_q), .bottom(bottom_q), .addr(cmd_addr), .hit(range_hit));

  fwp_gate u_gate (
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .wel(wel_q), .lock_bit(lock_q),
    .quad_en(quad_q), .guard_pin_n(guard_pin_n), .range_hit(range_hit),
    .lock_active(lock_active), .grant(grant), .deny(deny));

  fwp_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .grant(grant), .deny(deny),
    .wr_lock(new_status[7]), .wr_bp(new_status[4:2]),
    .wr_bottom(new_config[5]), .wr_quad(new_config[1]),
    .lock_q(lock_q), .bp_q(bp_q), .bottom_q(bottom_q), .quad_q(quad_q),
    .wel_q(wel_q), .acc_q(acc_q), .rej_q(rej_q));

  assign cmd_accept = acc_q;
  assign cmd_reject = rej_q;
  assign err_pulse  = rej_q;
  assign status_q   = {lock_q, 2'b00, bp_q, wel_q, 1'b0};
  assign config_q   = {2'b00, bottom_q, 3'b000, quad_q, 1'b0};
endmodule

// File: rtl/fwp_chk.sv
module fwp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [1:0] cmd_op,
  input logic       lock_active,
  input logic       range_hit,
  input logic       acc,
  input logic       rej,
  input logic [7:0] status_q,
  input logic [7:0] config_q
);
  // R5
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'b01 && lock_active) |=>
      (rej && status_q[7:2] == $past(status_q[7:2]) && config_q == $past(config_q)));

  // R10
  range_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op[1] && range_hit) |=> rej);

  // R3
  wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op != 2'b00) |=> !status_q[1]);

  // R2
  wren_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'b00) |=> (acc && status_q[1]));

  // R7
  quad_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'b01 && status_q[1] && config_q[1]) |=> acc);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> (!acc && !rej));

  // R11
  one_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> (acc != rej));
endmodule

bind flash_wprot_ctrl fwp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .lock_active(lock_active), .range_hit(range_hit), .acc(cmd_accept),
  .rej(cmd_reject), .status_q(status_q), .config_q(config_q));

// File: tb/sim_flash_wprot_ctrl.sv
`timescale 1ns/1ps
module sim_flash_wprot_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic guard_pin_n = 1'b1, cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [23:0] cmd_addr = '0;
  logic [7:0] new_status = '0, new_config = '0;
  logic cmd_accept, cmd_reject, err_pulse;
  logic [7:0] status_q, config_q;

  always #2.5 clk = ~clk;

  flash_wprot_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .guard_pin_n(guard_pin_n), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .new_status(new_status),
    .new_config(new_config), .cmd_accept(cmd_accept), .cmd_reject(cmd_reject),
    .err_pulse(err_pulse), .status_q(status_q), .config_q(config_q));

  typedef struct {
    bit        acc;
    bit [7:0]  st;
    bit [7:0]  cf;
    string     tag;
  } exp_t;
  exp_t sb[$];

  int checks = 0, fails = 0;
  bit done = 0;
  bit m_lock = 0, m_bot = 0, m_quad = 0, m_wel = 0;
  int m_bp = 0;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // protected-range test restated in 1/64 units of a 16 MiB array
  function automatic bit b_prot(int bp, bit bot, int addr);
    int units, idx;
    units = (bp == 0) ? 0 : (bp == 7) ? 64 : (1 << (bp - 1));
    idx = addr / 262144;
    return bot ? (idx < units) : (idx >= 64 - units);
  endfunction

  task automatic cmd(int op, int addr, int ns, int nc, string tag);
    exp_t e;
    bit ok;
    case (op)
      0: begin ok = 1; m_wel = 1; end
      1: begin
        ok = m_wel && !(m_lock && !guard_pin_n && !m_quad);
        if (ok) begin
          m_lock = ns[7]; m_bp = (ns >> 2) & 7; m_bot = nc[5]; m_quad = nc[1];
        end
        m_wel = 0;
      end
      default: begin ok = m_wel && !b_prot(m_bp, m_bot, addr); m_wel = 0; end
    endcase
    e.acc = ok;
    e.st = {m_lock, 2'b00, 3'(m_bp), m_wel, 1'b0};
    e.cf = {2'b00, m_bot, 3'b000, m_quad, 1'b0};
    e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    cmd_valid = 1; cmd_op = 2'(op); cmd_addr = 24'(addr);
    new_status = 8'(ns); new_config = 8'(nc);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wren();
    cmd(0, 0, 0, 0, "R2");
  endtask

  task automatic regw(bit lk, int bp, bit bot, bit qd, string tag);
    wren();
    cmd(1, 0, {lk, 2'b00, 3'(bp), 2'b11}, {2'b11, bot, 3'b111, qd, 1'b1}, tag);
  endtask

  task automatic prog(int op, int addr, string tag);
    wren();
    cmd(op, addr, 0, 0, tag);
  endtask

  task automatic set_pin(bit v);
    @(negedge clk);
    guard_pin_n = v;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && (cmd_accept || cmd_reject)) begin
      if (sb.size() == 0) begin
        check(0, "R11", "unexpected answer", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(cmd_accept == e.acc, e.tag, "accept", cmd_accept, e.acc);
        check(cmd_reject == !e.acc, e.tag, "reject", cmd_reject, !e.acc);
        check(err_pulse == cmd_reject, "R11", "err_pulse", err_pulse, cmd_reject);
        check(status_q == e.st, e.tag, "status", status_q, e.st);
        check(config_q == e.cf, e.tag, "config", config_q, e.cf);
      end
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(!cmd_accept && !cmd_reject && !err_pulse, "R11", "idle outputs",
            {cmd_accept, cmd_reject, err_pulse}, 0);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #500000;
    check(0, "watchdog", "timeout", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(status_q == 0 && config_q == 0, "R1", "regs at reset", {status_q, config_q}, 0);
    rst_n = 1;
    @(negedge clk);
    check(status_q == 0 && config_q == 0 && !cmd_accept && !cmd_reject && !err_pulse,
          "R1", "after reset", {status_q, config_q}, 0);
    // R3: no latch
    cmd(2, 24'h000100, 0, 0, "R3");
    cmd(1, 0, 8'h9C, 8'h22, "R3");
    wren();
    cmd(3, 24'h000100, 0, 0, "R3");
    idle(2);
    // R4, R8, R9 top ranges
    regw(0, 1, 0, 0, "R4");
    prog(2, 24'hFFFFFF, "R8");
    prog(2, 24'hFC0000, "R8");
    prog(2, 24'hFBFFFF, "R8");
    regw(0, 3, 0, 0, "R4");
    prog(2, 24'hF00000, "R8");
    prog(2, 24'hEFFFFF, "R8");
    regw(0, 6, 0, 0, "R4");
    prog(3, 24'h800000, "R8");
    prog(3, 24'h7FFFFF, "R8");
    regw(0, 7, 0, 0, "R4");
    prog(2, 24'h000000, "R8");
    regw(0, 0, 0, 0, "R4");
    prog(2, 24'hFFFFFF, "R8");
    // R9 bottom
    regw(0, 2, 1, 0, "R9");
    prog(2, 24'h07FFFF, "R9");
    prog(3, 24'h080000, "R9");
    prog(2, 24'hFFFFFF, "R9");
    // R5 lock set before pin low
    regw(1, 1, 0, 0, "R6");
    set_pin(0);
    regw(0, 0, 0, 0, "R5");
    regw(0, 5, 1, 1, "R5");
    prog(2, 24'hFC0010, "R10");
    prog(3, 24'h100000, "R10");
    // R6 pin high unlocks
    set_pin(1);
    regw(0, 1, 0, 0, "R6");
    // R6 pin low first, then lock
    set_pin(0);
    regw(1, 4, 0, 0, "R6");
    regw(0, 0, 0, 0, "R6");
    prog(2, 24'hE00000, "R10");
    // R7 quad mode bypass
    set_pin(1);
    regw(1, 2, 0, 1, "R7");
    set_pin(0);
    regw(1, 3, 0, 1, "R7");
    regw(1, 3, 0, 0, "R7");
    regw(0, 0, 0, 0, "R7");
    idle(3);
    check(sb.size() == 0, "R11", "pending expectations", sb.size(), 0);
    finish_run();
  end
endmodule